// File: doc/BRIEF.md
# Quad DAC Command Register Core

This block is the register and control heart of a four-channel voltage-output DAC. A serial front end hands it one finished command word at a time: a 4-bit operation code, a 4-bit channel selector and a 16-bit data field, qualified by a strobe that lasts one clock. The core acts on that word in the same clock edge, and its outputs show the result one cycle after the strobe.

Each channel has a staging register and an active register. Software can stage new codes on several channels and then move them to the outputs together, or write a channel and make it active in one step. The core also keeps a power-down flag for each channel and an enable for the on-chip reference. Any command that moves a code into the active register also clears the power-down flag of that channel. A strap input picks the code loaded at reset: zero-scale or mid-scale. The resolution is a parameter. A 12-bit build keeps the upper twelve bits of the data field.

Top module: `qdac_core`

## Requirements
- R1: The reset is synchronous and active low. During reset every staging and active code is loaded with zero when `por_mid` is 0, or with the value that has only the MSB set when `por_mid` is 1. Every power-down flag is cleared and `ref_en` is set to 1.
- R2: Operation 4'b0000 writes the data into the staging register of each selected channel. No active code changes.
- R3: Operation 4'b0001 copies the staging register of each selected channel into its active register and clears that channel's power-down flag.
- R4: Operation 4'b0010 writes the data into the staging register of each selected channel. In the same edge, every channel's active register takes its new staging value, and all power-down flags are cleared.
- R5: Operation 4'b0011 writes the data into both the staging and active registers of each selected channel and clears that channel's power-down flag.
- R6: Operation 4'b0100 sets the power-down flag of each selected channel. It leaves every code and `ref_en` unchanged.
- R7: Operation 4'b0101 sets all four power-down flags and clears `ref_en`, whatever the selector holds.
- R8: Operation 4'b0110 sets `ref_en`. Operation 4'b0111 clears it. The selector is not used by either.
- R9: Selector values 0 to 3 pick channels A to D, which sit at `dac_code` bits [15:0], [31:16], [47:32] and [63:48]. Selector 4'b1111 picks all four channels.
- R10: Operation 4'b1111 and the unused operations 4'b1000 to 4'b1110 change no code, flag or enable.
- R11: An operation from 4'b0000 to 4'b0100 that carries a selector from 4 to 14 changes nothing.
- R12: With `RES_BITS` = 12, a channel code is `cmd_data[15:4]` and `cmd_data[3:0]` has no effect. The mid-scale reset code is 12'h800.
- R13: A channel that is powered down keeps its staging and active codes. A later update of that channel restores the same active code and clears its flag.
- R14: State changes only at a clock edge where `cmd_valid` is 1. The result is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| por_mid | input | 1 | Reset-code strap: 0 selects zero-scale, 1 selects mid-scale |
| cmd_valid | input | 1 | One-cycle strobe that qualifies the command word |
| cmd_code | input | 4 | Operation code |
| cmd_addr | input | 4 | Channel selector |
| cmd_data | input | 16 | Data field |
| dac_code | output | NUM_CH*RES_BITS | Active codes, channel A in the lowest bits |
| pd_flag | output | NUM_CH | Power-down flag per channel, bit 0 is channel A |
| ref_en | output | 1 | Internal reference enable |

## Verification
On every clock cycle, the bound checker verifies the following:
- A cycle without a strobe, a no-operation or an unused operation leaves the outputs alone.
- Staging writes and power-down commands leave the active codes unchanged.
- The chip power-down, reference and update-all commands drive their flags to the required values.
- A combined write to channel A shows the data on its output.
- Reset produces the code chosen by the strap.

Some behaviour can only be shown by the bench's scenarios, where a reference model holds the staging contents:
- A staged value appears only after a later update.
- The update-all command mixes new data on one channel with older staged data on the others.
- Reserved selectors are ignored.
- Data survives a power-down.
- A 12-bit build drops the low bits of the data field.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
package qdac_pkg;

   localparam int CODE_W = 4;
   localparam int SEL_W  = 4;

   typedef enum logic [CODE_W-1:0] {
      OP_STAGE         = 4'h0,
      OP_COMMIT        = 4'h1,
      OP_STAGE_COMMIT_ALL = 4'h2,
      OP_WRITE_THROUGH = 4'h3,
      OP_SLEEP_CH      = 4'h4,
      OP_SLEEP_CHIP    = 4'h5,
      OP_REF_ON        = 4'h6,
      OP_REF_OFF       = 4'h7,
      OP_IDLE          = 4'hF
   } op_e;

   localparam logic [SEL_W-1:0] SEL_BROADCAST = 4'hF;

endpackage

// File: rtl/qdac_cmd_decode.sv
`timescale 1ns/1ps
module qdac_cmd_decode
   import qdac_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   input  logic [SEL_W-1:0]  sel,
   output logic [NUM_CH-1:0] stage_we,
   output logic [NUM_CH-1:0] commit_data,
   output logic [NUM_CH-1:0] commit_stage,
   output logic [NUM_CH-1:0] sleep_set,
   output logic [NUM_CH-1:0] sleep_clr,
   output logic              ref_set,
   output logic              ref_clr
);

   localparam logic [NUM_CH-1:0] ALL_CH = {NUM_CH{1'b1}};

   logic [NUM_CH-1:0] hit;
   logic              sel_legal;

   // per-channel selector match
   for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
      assign hit[i] = (sel == SEL_BROADCAST) || (sel == SEL_W'(i));
   end

   assign sel_legal = (int'(sel) < NUM_CH) || (sel == SEL_BROADCAST);

   always_comb begin
      stage_we     = '0;
      commit_data  = '0;
      commit_stage = '0;
      sleep_set    = '0;
      sleep_clr    = '0;
      ref_set      = 1'b0;
      ref_clr      = 1'b0;
      if (valid) begin
         case (code)
            OP_STAGE: begin
               stage_we = hit;
            end
            OP_COMMIT: begin
               commit_stage = hit;
               sleep_clr    = hit;
            end
            OP_STAGE_COMMIT_ALL: begin
               if (sel_legal) begin
                  stage_we     = hit;
                  commit_data  = hit;
                  commit_stage = ~hit;
                  sleep_clr    = ALL_CH;
               end
            end
            OP_WRITE_THROUGH: begin
               stage_we    = hit;
               commit_data = hit;
               sleep_clr   = hit;
            end
            OP_SLEEP_CH: begin
               sleep_set = hit;
            end
            OP_SLEEP_CHIP: begin
               sleep_set = ALL_CH;
               ref_clr   = 1'b1;
            end
            OP_REF_ON:  ref_set = 1'b1;
            OP_REF_OFF: ref_clr = 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/qdac_channel.sv
`timescale 1ns/1ps
module qdac_channel #(
   parameter int RES_BITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RES_BITS-1:0] reset_code,
   input  logic [RES_BITS-1:0] wr_code,
   input  logic                stage_we,
   input  logic                commit_data,
   input  logic                commit_stage,
   input  logic                sleep_set,
   input  logic                sleep_clr,
   output logic [RES_BITS-1:0] active_code,
   output logic                asleep
);

   logic [RES_BITS-1:0] staged_q;
   logic [RES_BITS-1:0] active_q;
   logic                sleep_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged_q <= reset_code;
      end else if (stage_we) begin
         staged_q <= wr_code;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= reset_code;
      end else if (commit_data) begin
         active_q <= wr_code;
      end else if (commit_stage) begin
         active_q <= staged_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sleep_q <= 1'b0;
      end else if (sleep_set) begin
         sleep_q <= 1'b1;
      end else if (sleep_clr) begin
         sleep_q <= 1'b0;
      end
   end

   assign active_code = active_q;
   assign asleep      = sleep_q;

endmodule

// File: rtl/qdac_core.sv
`timescale 1ns/1ps
module qdac_core
   import qdac_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int RES_BITS = 16,
   parameter int DATA_W   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       por_mid,
   input  logic                       cmd_valid,
   input  logic [3:0]                 cmd_code,
   input  logic [3:0]                 cmd_addr,
   input  logic [DATA_W-1:0]          cmd_data,
   output logic [NUM_CH*RES_BITS-1:0] dac_code,
   output logic [NUM_CH-1:0]          pd_flag,
   output logic                       ref_en
);

   localparam logic [RES_BITS-1:0] MID_CODE  = {1'b1, {(RES_BITS-1){1'b0}}};
   localparam logic [RES_BITS-1:0] ZERO_CODE = '0;

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > 15) begin : g_bad_ch
      $error("qdac_core: NUM_CH must be 1..15");
   end
   if (RES_BITS < 2 || RES_BITS > DATA_W) begin : g_bad_res
      $error("qdac_core: RES_BITS must be 2..DATA_W");
   end

   logic [RES_BITS-1:0] wr_code;
   logic [RES_BITS-1:0] reset_code;
   logic [NUM_CH-1:0]   stage_we, commit_data, commit_stage, sleep_set, sleep_clr;
   logic                ref_set, ref_clr;
   logic                ref_q;

   // data field alignment: full width or upper bits only
   if (RES_BITS == DATA_W) begin : g_full_res
      assign wr_code = cmd_data;
   end else begin : g_trunc_res
      logic [DATA_W-RES_BITS-1:0] dropped_bits;
      assign wr_code      = cmd_data[DATA_W-1 -: RES_BITS];
      assign dropped_bits = cmd_data[DATA_W-RES_BITS-1:0];
   end

   assign reset_code = por_mid ? MID_CODE : ZERO_CODE;

   qdac_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
      .valid        (cmd_valid),
      .code         (cmd_code),
      .sel          (cmd_addr),
      .stage_we     (stage_we),
      .commit_data  (commit_data),
      .commit_stage (commit_stage),
      .sleep_set    (sleep_set),
      .sleep_clr    (sleep_clr),
      .ref_set      (ref_set),
      .ref_clr      (ref_clr)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      qdac_channel #(.RES_BITS(RES_BITS)) u_ch (
         .clk          (clk),
         .rst_n        (rst_n),
         .reset_code   (reset_code),
         .wr_code      (wr_code),
         .stage_we     (stage_we[i]),
         .commit_data  (commit_data[i]),
         .commit_stage (commit_stage[i]),
         .sleep_set    (sleep_set[i]),
         .sleep_clr    (sleep_clr[i]),
         .active_code  (dac_code[i*RES_BITS +: RES_BITS]),
         .asleep       (pd_flag[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= 1'b1;
      end else if (ref_clr) begin
         ref_q <= 1'b0;
      end else if (ref_set) begin
         ref_q <= 1'b1;
      end
   end

   assign ref_en = ref_q;

endmodule

// File: rtl/qdac_core_chk.sv
`timescale 1ns/1ps
module qdac_core_chk #(
   parameter int NUM_CH   = 4,
   parameter int RES_BITS = 16,
   parameter int DATA_W   = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       por_mid,
   input logic                       cmd_valid,
   input logic [3:0]                 cmd_code,
   input logic [3:0]                 cmd_addr,
   input logic [DATA_W-1:0]          cmd_data,
   input logic [NUM_CH*RES_BITS-1:0] dac_code,
   input logic [NUM_CH-1:0]          pd_flag,
   input logic                       ref_en
);

   localparam logic [NUM_CH*RES_BITS-1:0] ALL_MID =
      {NUM_CH{1'b1, {(RES_BITS-1){1'b0}}}};

   logic sel_ok;
   logic sel_a;
   logic op_unused;
   assign sel_ok    = (int'(cmd_addr) < NUM_CH) || (cmd_addr == 4'hF);
   assign sel_a     = (cmd_addr == 4'h0) || (cmd_addr == 4'hF);
   assign op_unused = cmd_code[3];

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      (!rst_n && !por_mid) |=> (dac_code == '0 && pd_flag == '0 && ref_en));

   // R1
   reset_mid_chk: assert property (@(posedge clk)
      (!rst_n && por_mid) |=> (dac_code == ALL_MID && pd_flag == '0 && ref_en));

   // R2
   stage_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'h0) |=> $stable(dac_code));

   // R3
   commit_wakes_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'h1 && sel_a) |=> !pd_flag[0]);

   // R4
   commit_all_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'h2 && sel_ok) |=> (pd_flag == '0));

   // R5
   write_through_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'h3 && sel_a) |=>
      (dac_code[RES_BITS-1:0] == $past(cmd_data[DATA_W-1 -: RES_BITS]) && !pd_flag[0]));

   // R6
   sleep_ch_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'h4) |=> ($stable(dac_code) && $stable(ref_en)));

   // R7
   sleep_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'h5) |=> (pd_flag == '1 && !ref_en));

   // R8
   ref_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'h6) |=> ref_en);

   // R8
   ref_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 4'h7) |=> !ref_en);

   // R10
   unused_op_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op_unused) |=>
      ($stable(dac_code) && $stable(pd_flag) && $stable(ref_en)));

   // R11
   bad_sel_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_code[3] && cmd_code <= 4'h4 && !sel_ok) |=>
      ($stable(dac_code) && $stable(pd_flag) && $stable(ref_en)));

   // R14
   idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(dac_code) && $stable(pd_flag) && $stable(ref_en)));

endmodule

bind qdac_core qdac_core_chk #(
   .NUM_CH   (NUM_CH),
   .RES_BITS (RES_BITS),
   .DATA_W   (DATA_W)
) u_qdac_core_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .por_mid   (por_mid),
   .cmd_valid (cmd_valid),
   .cmd_code  (cmd_code),
   .cmd_addr  (cmd_addr),
   .cmd_data  (cmd_data),
   .dac_code  (dac_code),
   .pd_flag   (pd_flag),
   .ref_en    (ref_en)
);

// File: tb/tb_qdac_core.sv
`timescale 1ns/1ps
module tb_qdac_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_mid = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_code = 4'h0;
   logic [3:0]  cmd_addr = 4'h0;
   logic [15:0] cmd_data = 16'h0;
   logic [63:0] dac_code;
   logic [47:0] dac_code12;
   logic [3:0]  pd_flag, pd_flag12;
   logic        ref_en, ref_en12;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   logic [15:0] m_stage [4];
   logic [15:0] m_act   [4];
   logic [3:0]  m_pd;
   logic        m_ref;

   // scoreboard queues
   logic [63:0] q_dac [$];
   logic [3:0]  q_pd  [$];
   logic        q_ref [$];
   string       q_tag [$];

   always #2.5 clk = ~clk;

   qdac_core dut (
      .clk(clk), .rst_n(rst_n), .por_mid(por_mid), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .dac_code(dac_code), .pd_flag(pd_flag), .ref_en(ref_en)
   );

   qdac_core #(.RES_BITS(12)) dut12 (
      .clk(clk), .rst_n(rst_n), .por_mid(por_mid), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .dac_code(dac_code12), .pd_flag(pd_flag12), .ref_en(ref_en12)
   );

   function automatic bit picks(input logic [3:0] a, input int ch);
      return (a == 4'hF) || (int'(a) == ch);
   endfunction

   function automatic void model_apply(input logic [3:0] c, input logic [3:0] a,
                                       input logic [15:0] d);
      bit legal;
      legal = (a < 4'd4) || (a == 4'hF);
      case (c)
         4'h0: for (int ch = 0; ch < 4; ch++) if (picks(a, ch)) m_stage[ch] = d;
         4'h1: for (int ch = 0; ch < 4; ch++)
                  if (picks(a, ch)) begin m_act[ch] = m_stage[ch]; m_pd[ch] = 1'b0; end
         4'h2: if (legal) begin
                  for (int ch = 0; ch < 4; ch++) if (picks(a, ch)) m_stage[ch] = d;
                  for (int ch = 0; ch < 4; ch++) m_act[ch] = m_stage[ch];
                  m_pd = 4'h0;
               end
         4'h3: for (int ch = 0; ch < 4; ch++)
                  if (picks(a, ch)) begin
                     m_stage[ch] = d; m_act[ch] = d; m_pd[ch] = 1'b0;
                  end
         4'h4: for (int ch = 0; ch < 4; ch++) if (picks(a, ch)) m_pd[ch] = 1'b1;
         4'h5: begin m_pd = 4'hF; m_ref = 1'b0; end
         4'h6: m_ref = 1'b1;
         4'h7: m_ref = 1'b0;
         default: ;
      endcase
   endfunction

   task automatic push_expect(input string tag);
      logic [63:0] flat;
      for (int ch = 0; ch < 4; ch++) flat[ch*16 +: 16] = m_act[ch];
      q_dac.push_back(flat);
      q_pd.push_back(m_pd);
      q_ref.push_back(m_ref);
      q_tag.push_back(tag);
   endtask

   // called at a negedge
   task automatic do_reset(input logic strap);
      rst_n = 1'b0; por_mid = strap; cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      for (int ch = 0; ch < 4; ch++) begin
         m_stage[ch] = strap ? 16'h8000 : 16'h0000;
         m_act[ch]   = strap ? 16'h8000 : 16'h0000;
      end
      m_pd = 4'h0; m_ref = 1'b1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      push_expect("R1");
      @(negedge clk);
   endtask

   // called at a negedge; result checked at the following negedge
   task automatic send(input logic [3:0] c, input logic [3:0] a,
                       input logic [15:0] d, input string tag);
      cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
      model_apply(c, a, d);
      @(posedge clk); #1;
      push_expect(tag);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // R14: command word present but no strobe
   task automatic idle_word(input logic [3:0] c, input logic [3:0] a,
                            input logic [15:0] d);
      cmd_valid = 1'b0; cmd_code = c; cmd_addr = a; cmd_data = d;
      @(posedge clk); #1;
      push_expect("R14");
      @(negedge clk);
   endtask

   // monitor: compare against scoreboard away from the active edge
   always @(negedge clk) begin
      if (q_tag.size() > 0) begin
         logic [63:0] e_dac;
         logic [47:0] e12;
         logic [3:0]  e_pd;
         logic        e_ref;
         string       tag;
         bit          bad;
         e_dac = q_dac.pop_front();
         e_pd  = q_pd.pop_front();
         e_ref = q_ref.pop_front();
         tag   = q_tag.pop_front();
         for (int ch = 0; ch < 4; ch++) e12[ch*12 +: 12] = e_dac[ch*16+4 +: 12];
         bad = 1'b0;
         checks++;
         if (dac_code !== e_dac) begin
            $display("FAIL %s dac_code actual=%h expected=%h", tag, dac_code, e_dac);
            bad = 1'b1;
         end
         if (pd_flag !== e_pd) begin
            $display("FAIL %s pd_flag actual=%b expected=%b", tag, pd_flag, e_pd);
            bad = 1'b1;
         end
         if (ref_en !== e_ref) begin
            $display("FAIL %s ref_en actual=%b expected=%b", tag, ref_en, e_ref);
            bad = 1'b1;
         end
         if (dac_code12 !== e12 || pd_flag12 !== e_pd || ref_en12 !== e_ref) begin
            $display("FAIL R12 (%s) 12-bit build actual=%h/%b/%b expected=%h/%b/%b",
                     tag, dac_code12, pd_flag12, ref_en12, e12, e_pd, e_ref);
            bad = 1'b1;
         end
         if (bad) errors++;
      end
   end

   initial begin
      @(negedge clk);
      do_reset(1'b0);                               // R1 zero-scale strap
      send(4'h0, 4'h0, 16'h1234, "R2");             // stage A only
      send(4'h1, 4'h0, 16'hDEAD, "R3");             // commit A from stage
      send(4'h0, 4'h1, 16'hABCD, "R9");             // stage B
      send(4'h0, 4'h2, 16'h5555, "R9");             // stage C
      send(4'h4, 4'h3, 16'h0000, "R6");             // sleep D
      send(4'h2, 4'h3, 16'h0F0F, "R4");             // stage D, commit all
      send(4'h3, 4'hF, 16'h7777, "R5");             // broadcast write-through
      send(4'h3, 4'h1, 16'hC3A5, "R5");             // write-through B
      send(4'h4, 4'h1, 16'h0000, "R6");             // sleep B
      send(4'h1, 4'h1, 16'h0000, "R13");           // wake B, code kept
      send(4'h5, 4'h9, 16'h0000, "R7");             // chip sleep
      send(4'h6, 4'h0, 16'h0000, "R8");             // reference on
      send(4'h3, 4'h2, 16'hFFFF, "R5");             // wake C only
      send(4'h7, 4'h3, 16'h0000, "R8");             // reference off
      send(4'h6, 4'hA, 16'h0000, "R8");             // reference on, odd selector
      send(4'h8, 4'h0, 16'h1111, "R10");            // unused op
      send(4'hC, 4'hF, 16'h2222, "R10");            // unused op
      send(4'hF, 4'hF, 16'h3333, "R10");            // no-operation
      send(4'h0, 4'h5, 16'h4444, "R11");            // bad selector stage
      send(4'h3, 4'h9, 16'h5555, "R11");            // bad selector write-through
      send(4'h2, 4'h4, 16'h6666, "R11");            // bad selector commit-all
      send(4'h4, 4'hE, 16'h0000, "R11");            // bad selector sleep
      send(4'h1, 4'hF, 16'h0000, "R11");            // commit all, stages unchanged
      idle_word(4'h3, 4'hF, 16'h9999);              // R14 no strobe
      send(4'h3, 4'h0, 16'hFEDC, "R12");            // low nibble dropped in 12-bit
      send(4'h3, 4'h0, 16'hFED3, "R12");            // differs only in low nibble
      do_reset(1'b1);                               // R1 mid-scale strap
      send(4'h4, 4'hF, 16'h0000, "R9");             // broadcast sleep
      send(4'h1, 4'h2, 16'h0000, "R13");            // wake C: mid-scale kept
      send(4'h2, 4'h0, 16'h1357, "R4");             // stage A, commit all
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule